// File: doc/BRIEF.md
# UART Interrupt Source Aggregator

This block collects ten status and error events from a UART with receive and transmit FIFOs and a buffer-based DMA channel, and turns them into a single registered interrupt request for the chip's top-level interrupt controller. Each event is caught in a sticky flag bit. Software reads the flags and clears them by writing 1s. A per-source enable register decides which latched flags may request service. A top-level enable gates the whole output.

Three kinds of trigger share one flag register:
- **FIFO status sources.** The transmitter-idle, transmit-has-room and receive-has-data status lines trigger either on a rising edge or on a high level. A mode input chooses which.
- **DMA buffer completions.** The four completions (transmit A/B, receive A/B) trigger when the buffer's active indication drops from 1 to 0.
- **Receive errors.** Parity error, framing error and receive overrun arrive as single-cycle pulses and set their flags directly.

The block contains neither the UART datapath nor the DMA engine.

Top module: `uart_irq_agg`

## Requirements
- R1: While `rstN` is low, and on the first cycle after reset, `flags` reads 0 and `irq` is 0. The enable register also resets to 0.
- R2: Flag bit positions are fixed as follows: 0 = tx idle, 1 = tx free, 2 = rx valid, 3 = tx buffer A done, 4 = tx buffer B done, 5 = rx buffer A done, 6 = rx buffer B done, 7 = parity error, 8 = framing error, 9 = overrun. `enData` and `clrData` use the same positions.
- R3: With `levelMode` = 0, a status flag (bits 0..2) is set in the cycle after its input goes from 0 to 1. An input that stays high does not set the flag again once it has been cleared.
- R4: With `levelMode` = 1, a status flag is set whenever its input is high. It still reads 1 in the cycle after a clear write, as long as the input stays high.
- R5: A DMA completion flag (bits 3..6) is set in the cycle after its active input goes from 1 to 0. A 0-to-1 change sets nothing.
- R6: A one-cycle pulse on an error input sets the matching flag (bits 7..9) in the next cycle.
- R7: When `clrWrite` is high, every flag whose `clrData` bit is 1 reads 0 in the next cycle. Flags whose `clrData` bit is 0 keep their value.
- R8: If a set event and a clear write hit the same flag in the same cycle, the flag reads 1 afterwards.
- R9: `enWrite` loads `enData` into the enable register. `irq` is a register that equals `topEnable` AND the OR over all bits of (flag AND enable). It follows a flag change one cycle later.
- R10: Flags are latched whether or not they are enabled. With `topEnable` low, `irq` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| levelMode | input | 1 | 1 = status sources trigger on level, 0 = on rising edge |
| txIdle | input | 1 | Transmit FIFO empty and shifter done |
| txFree | input | 1 | Transmit FIFO has room |
| rxValid | input | 1 | Receive FIFO holds data |
| txDmaActA | input | 1 | Transmit buffer A active |
| txDmaActB | input | 1 | Transmit buffer B active |
| rxDmaActA | input | 1 | Receive buffer A active |
| rxDmaActB | input | 1 | Receive buffer B active |
| parityErr | input | 1 | One-cycle parity error pulse |
| frameErr | input | 1 | One-cycle framing error pulse |
| overrunErr | input | 1 | One-cycle receive overrun pulse |
| enWrite | input | 1 | Load enable register |
| enData | input | 10 | New per-source enable bits |
| clrWrite | input | 1 | Clear-by-writing-1 strobe |
| clrData | input | 10 | Flags to clear |
| topEnable | input | 1 | Top-level interrupt enable |
| flags | output | 10 | Latched source flags |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench goes after a status input that stays high across a clear write while in edge mode. A design that treated the input as a level would set the flag again. It then repeats that pattern in level mode, where a design that let the clear win would show a zero for one cycle. A DMA active line that rises and later falls checks the polarity: a detector built for rising edges would flag the rise instead of the fall. A clear write that lands on an error pulse's cycle must leave the flag set. The `irq` checks sample one cycle after the flag change, so an unregistered output, or one that ignores the enable register or the top-level enable, shows up at once.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  parameter int NUM_STATUS = 3;
  parameter int NUM_DMA    = 4;
  parameter int NUM_ERR    = 3;
  localparam int NUM_SRC   = NUM_STATUS + NUM_DMA + NUM_ERR;
  localparam int DMA_LO    = NUM_STATUS;
  localparam int ERR_LO    = NUM_STATUS + NUM_DMA;

  typedef struct packed {
    logic [NUM_SRC-1:0] setVec;
    logic [NUM_SRC-1:0] clrVec;
    logic               enLoad;
    logic [NUM_SRC-1:0] enVal;
  } strobe_t;
endpackage

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  levelMode,
  input  logic [NUM_STATUS-1:0] statusIn,
  input  logic [NUM_DMA-1:0]    dmaAct,
  input  logic [NUM_ERR-1:0]    errPulse,
  input  logic                  clrWrite,
  input  logic [NUM_SRC-1:0]    clrData,
  input  logic                  enWrite,
  input  logic [NUM_SRC-1:0]    enData,
  output strobe_t               strobe
);
  logic [NUM_STATUS-1:0] statusPrev;
  logic [NUM_DMA-1:0]    dmaPrev;
  logic [NUM_STATUS-1:0] statusSet;
  logic [NUM_DMA-1:0]    dmaSet;

  // Previous-cycle samples for the edge detectors
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusPrev <= '0;
      dmaPrev    <= '0;
    end else begin
      statusPrev <= statusIn;
      dmaPrev    <= dmaAct;
    end
  end

  // Status sources: rising edge or high level, chosen by levelMode
  for (genvar g = 0; g < NUM_STATUS; g++) begin : g_status
    assign statusSet[g] = levelMode ? statusIn[g] : (statusIn[g] & ~statusPrev[g]);
  end

  // DMA completions: falling edge of the active indication
  for (genvar g = 0; g < NUM_DMA; g++) begin : g_dma
    assign dmaSet[g] = dmaPrev[g] & ~dmaAct[g];
  end

  always_comb begin
    strobe.setVec = {errPulse, dmaSet, statusSet};
    strobe.clrVec = clrWrite ? clrData : '0;
    strobe.enLoad = enWrite;
    strobe.enVal  = enData;
  end

  for (genvar g = 0; g < NUM_STATUS; g++) begin : g_status_chk
    AST_STATUS_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      strobe.setVec[g] |-> statusIn[g]); // R3
  end
  for (genvar g = 0; g < NUM_DMA; g++) begin : g_dma_chk
    AST_DMA_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
      strobe.setVec[DMA_LO+g] |-> !dmaAct[g]); // R5
  end
endmodule

// File: rtl/uirq_datapath.sv
module uirq_datapath
  import uirq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic               topEnable,
  output logic [NUM_SRC-1:0] flags,
  output logic               irq
);
  logic [NUM_SRC-1:0] enableReg;
  logic               anyPending;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags     <= '0;
      enableReg <= '0;
    end else begin
      flags <= (flags & ~strobe.clrVec) | strobe.setVec;
      if (strobe.enLoad) enableReg <= strobe.enVal;
    end
  end

  assign anyPending = |(flags & enableReg);

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= topEnable & anyPending;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag_chk
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
      strobe.setVec[g] |=> flags[g]); // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.clrVec[g] && !strobe.setVec[g]) |=> !flags[g]); // R7
  end
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.setVec == '0 && strobe.clrVec == '0) |=> $stable(flags)); // R7
  AST_TOP_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !topEnable |=> !irq); // R10
endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg
  import uirq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               levelMode,
  input  logic               txIdle,
  input  logic               txFree,
  input  logic               rxValid,
  input  logic               txDmaActA,
  input  logic               txDmaActB,
  input  logic               rxDmaActA,
  input  logic               rxDmaActB,
  input  logic               parityErr,
  input  logic               frameErr,
  input  logic               overrunErr,
  input  logic               enWrite,
  input  logic [NUM_SRC-1:0] enData,
  input  logic               clrWrite,
  input  logic [NUM_SRC-1:0] clrData,
  input  logic               topEnable,
  output logic [NUM_SRC-1:0] flags,
  output logic               irq
);
  strobe_t strobe;

  uirq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .levelMode (levelMode),
    .statusIn  ({rxValid, txFree, txIdle}),
    .dmaAct    ({rxDmaActB, rxDmaActA, txDmaActB, txDmaActA}),
    .errPulse  ({overrunErr, frameErr, parityErr}),
    .clrWrite  (clrWrite),
    .clrData   (clrData),
    .enWrite   (enWrite),
    .enData    (enData),
    .strobe    (strobe)
  );

  uirq_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .topEnable (topEnable),
    .flags     (flags),
    .irq       (irq)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (flags == '0 && !irq)); // R1
endmodule

// File: tb/tb_uart_irq_agg.sv
module tb_uart_irq_agg;
  logic clk = 1'b0;
  logic rstN;
  logic levelMode, txIdle, txFree, rxValid;
  logic txDmaActA, txDmaActB, rxDmaActA, rxDmaActB;
  logic parityErr, frameErr, overrunErr;
  logic enWrite, clrWrite, topEnable;
  logic [9:0] enData, clrData, flags;
  logic irq;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  uart_irq_agg dut (.*);

  // {levelMode, status[2:0], dma[3:0], err[2:0], clr[9:0], expFlags[9:0]}
  // status: 0 txIdle,1 txFree,2 rxValid; dma: 0 txA,1 txB,2 rxA,3 rxB; err: 0 parity,1 frame,2 overrun
  localparam int NV = 16;
  localparam logic [30:0] VECS [NV] = '{
    {1'b0, 3'b000, 4'b0000, 3'b000, 10'h000, 10'h000}, // idle
    {1'b0, 3'b001, 4'b0000, 3'b000, 10'h000, 10'h001}, // R3 rise
    {1'b0, 3'b001, 4'b0000, 3'b000, 10'h001, 10'h000}, // R3 R7 clear while high
    {1'b0, 3'b001, 4'b0000, 3'b000, 10'h000, 10'h000}, // R3 no re-set
    {1'b0, 3'b001, 4'b1111, 3'b000, 10'h000, 10'h000}, // R5 rise ignored
    {1'b0, 3'b001, 4'b1110, 3'b000, 10'h000, 10'h008}, // R5 txA fall
    {1'b0, 3'b001, 4'b0000, 3'b000, 10'h000, 10'h078}, // R5 R2 rest fall
    {1'b0, 3'b001, 4'b0000, 3'b001, 10'h000, 10'h0F8}, // R6 parity
    {1'b0, 3'b001, 4'b0000, 3'b110, 10'h078, 10'h380}, // R6 R7 partial clear
    {1'b1, 3'b001, 4'b0000, 3'b000, 10'h000, 10'h381}, // R4 level sets
    {1'b1, 3'b001, 4'b0000, 3'b000, 10'h001, 10'h381}, // R4 stays after clear
    {1'b1, 3'b000, 4'b0000, 3'b000, 10'h001, 10'h380}, // R4 low then clear
    {1'b1, 3'b110, 4'b0000, 3'b000, 10'h000, 10'h386}, // R4 R2 txFree rxValid
    {1'b0, 3'b110, 4'b0000, 3'b000, 10'h006, 10'h380}, // R3 edge mode, steady high
    {1'b0, 3'b000, 4'b0000, 3'b000, 10'h3FF, 10'h000}, // R7 clear all
    {1'b0, 3'b000, 4'b0000, 3'b001, 10'h080, 10'h080}  // R8 set beats clear
  };

  task automatic chk(string req, logic [9:0] act, logic [9:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000ns;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; levelMode = 1'b0; txIdle = 1'b0; txFree = 1'b0; rxValid = 1'b0;
    txDmaActA = 1'b0; txDmaActB = 1'b0; rxDmaActA = 1'b0; rxDmaActB = 1'b0;
    parityErr = 1'b0; frameErr = 1'b0; overrunErr = 1'b0;
    enWrite = 1'b0; clrWrite = 1'b0; topEnable = 1'b0; enData = '0; clrData = '0;
    tick(); tick();
    chk("R1 flags", flags, 10'h000);
    chk("R1 irq", {9'd0, irq}, 10'h000);
    rstN = 1'b1;
    tick();
    chk("R1 after release", flags, 10'h000);

    for (int i = 0; i < NV; i++) begin
      {levelMode, rxValid, txFree, txIdle} = VECS[i][30:27];
      {rxDmaActB, rxDmaActA, txDmaActB, txDmaActA} = VECS[i][26:23];
      {overrunErr, frameErr, parityErr} = VECS[i][22:20];
      clrData = VECS[i][19:10];
      clrWrite = (VECS[i][19:10] != 10'h000);
      tick();
      chk($sformatf("R2 vector %0d flags", i), flags, VECS[i][9:0]);
      chk($sformatf("R10 vector %0d irq masked", i), {9'd0, irq}, 10'h000);
    end
    parityErr = 1'b0; frameErr = 1'b0; overrunErr = 1'b0;
    clrWrite = 1'b0; clrData = '0;

    // R9: enable parity, top enable on; irq one cycle after enable lands
    enWrite = 1'b1; enData = 10'h080; topEnable = 1'b1;
    tick();
    enWrite = 1'b0;
    chk("R9 irq latency", {9'd0, irq}, 10'h000);
    tick();
    chk("R9 irq asserted", {9'd0, irq}, 10'h001);

    // R10: top enable gates
    topEnable = 1'b0;
    tick();
    chk("R10 top gate", {9'd0, irq}, 10'h000);
    chk("R10 flag kept", flags, 10'h080);

    // R9: clearing drops irq one cycle after the flag
    topEnable = 1'b1;
    tick();
    chk("R9 irq back", {9'd0, irq}, 10'h001);
    clrWrite = 1'b1; clrData = 10'h080;
    tick();
    clrWrite = 1'b0; clrData = '0;
    chk("R7 flag cleared", flags, 10'h000);
    chk("R9 irq lags flag", {9'd0, irq}, 10'h001);
    tick();
    chk("R9 irq dropped", {9'd0, irq}, 10'h000);

    // R9: non-enabled flag does not request
    enWrite = 1'b1; enData = 10'h001;
    tick();
    enWrite = 1'b0;
    overrunErr = 1'b1;
    tick();
    overrunErr = 1'b0;
    chk("R6 overrun", flags, 10'h200);
    tick();
    chk("R9 masked source", {9'd0, irq}, 10'h000);

    // R1: reset mid-run clears flags and irq
    rstN = 1'b0;
    tick();
    chk("R1 mid reset flags", flags, 10'h000);
    chk("R1 mid reset irq", {9'd0, irq}, 10'h000);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule